// File: doc/BRIEF.md
# Event-driven system clock rate selector

This block produces the enable pulses that pace the general system clock of a chip from a fast base clock. Nothing downstream is clocked from a divided net. Each consumer gates its flops with `sys_ce`, and `sys2x_ce` serves logic that needs twice that rate. The base period is two input clock cycles, so the undivided (normal) rate is the fastest one available.

Software programs a control register through a small synchronous write port. The register selects between the always-normal rate and a power-saving scheme. In that scheme the clock runs at a programmable low rate until something needs more throughput. A pending interrupt above a programmed level, or a busy RISC engine whose request enable is set, raises the rate to a programmable high rate without any software action. When the request goes away, the rate drops back to low. A rate change is applied only where the current divided period ends, so no shortened pulse is ever produced.

A separate timer enable is derived from the same input clock. Two mode pins make it either undivided or divided by 128.

Top module: `sysclk_rate_ctrl`

## Requirements
- R1: After reset the control register reads 0, `rate_o` is 0, and `sys_ce` pulses every 2 clock cycles.
- R2: A write with `cfg_addr` equal to the control address (default 0) stores `cfg_wdata[10:0]`. Reading at that address returns the stored bits and zeros above bit 10. Field positions are: bit 0 source select, bits 3:1 low code, bits 6:4 high code, bits 9:7 interrupt threshold, bit 10 RISC request enable. Writes to any other address leave the register unchanged, and reads there return 0.
- R3: With source select 0, the normal rate (period 2) is used whatever the codes, interrupt level or RISC state.
- R4: With source select 1 and no fast request, the `sys_ce` period is 2*4^L cycles, where L is the low code.
- R5: A fast request is raised when `irq_level` is strictly greater than the threshold. An equal level gives no fast request.
- R6: A fast request is raised when the RISC request enable is 1 and `risc_busy` is 1. With the enable at 0, `risc_busy` has no effect.
- R7: While a fast request is active, the period is 2*4^H, where H is the high code. H = 0 gives the normal period of 2.
- R8: A rate change takes effect only after the `sys_ce` pulse that ends the period in progress. That period keeps its old length.
- R9: `sys2x_ce` pulses exactly twice per `sys_ce` period: once at the middle and once together with `sys_ce`.
- R10: `tmr_ce` is high every cycle when `mode_pins` is 11. For any other value it pulses once every 128 cycles.
- R11: `rate_o` reports the applied rate as 0 normal, 1 low, 2 high, updated at the same boundary as the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, twice the normal system rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 4 | Register address for write and read |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for `cfg_addr` |
| irq_level | input | 3 | Highest pending interrupt level |
| risc_busy | input | 1 | RISC engine not idle |
| mode_pins | input | 2 | Timer prescale mode |
| sys_ce | output | 1 | General system clock enable |
| sys2x_ce | output | 1 | Enable at twice the system rate |
| tmr_ce | output | 1 | Timer clock enable |
| rate_o | output | 2 | Applied rate: 0 normal, 1 low, 2 high |

## Verification
The bench uses the default parameters: 3-bit divider codes, a 7-bit timer prescaler and control address 0. Codes 0 to 3 are exercised, so periods run from 2 up to 128 cycles. That range covers both the pass-through code and a long period in which a mid-period reconfiguration can be shown to wait for the boundary. The 128-cycle timer division is reachable in a few hundred cycles, and the interrupt threshold is probed at equality and one level above.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

   typedef enum logic [1:0] {
      RATE_NORM = 2'd0,
      RATE_LOW  = 2'd1,
      RATE_HIGH = 2'd2
   } rate_e;

   localparam int unsigned THR_W = 3;

   function automatic int unsigned cfg_bits(input int unsigned div_w);
      return 1 + 2 * div_w + THR_W + 1;
   endfunction

endpackage

// File: rtl/sysclk_cfg_regs.sv
module sysclk_cfg_regs
   import sysclk_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned DIV_W     = 3,
   parameter int unsigned CTRL_ADDR = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    wr_en,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [DATA_W-1:0]       rd_data,
   output logic                    src_sel,
   output logic [DIV_W-1:0]        low_code,
   output logic [DIV_W-1:0]        high_code,
   output logic [THR_W-1:0]        irq_thr,
   output logic                    risc_en
);
   localparam int unsigned USED_W = cfg_bits(DIV_W);
   localparam int unsigned LO_LSB = 1;
   localparam int unsigned HI_LSB = LO_LSB + DIV_W;
   localparam int unsigned TH_LSB = HI_LSB + DIV_W;
   localparam int unsigned RE_BIT = TH_LSB + THR_W;

   logic [USED_W-1:0] ctrl_q;
   logic              hit;

   assign hit = (addr == ADDR_W'(CTRL_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (wr_en && hit)
         ctrl_q <= wr_data[USED_W-1:0];
   end

   assign rd_data   = hit ? DATA_W'(ctrl_q) : '0;
   assign src_sel   = ctrl_q[0];
   assign low_code  = ctrl_q[LO_LSB +: DIV_W];
   assign high_code = ctrl_q[HI_LSB +: DIV_W];
   assign irq_thr   = ctrl_q[TH_LSB +: THR_W];
   assign risc_en   = ctrl_q[RE_BIT];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit) |=> ctrl_q == $past(wr_data[USED_W-1:0])); // R2
   AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hit) |=> $stable(ctrl_q)); // R2

endmodule

// File: rtl/sysclk_rate_policy.sv
module sysclk_rate_policy
   import sysclk_pkg::*;
#(
   parameter int unsigned DIV_W = 3
) (
   input  logic              src_sel,
   input  logic [DIV_W-1:0]  low_code,
   input  logic [DIV_W-1:0]  high_code,
   input  logic [THR_W-1:0]  irq_thr,
   input  logic              risc_en,
   input  logic [THR_W-1:0]  irq_level,
   input  logic              risc_busy,
   output logic [DIV_W-1:0]  want_code,
   output rate_e             want_rate
);
   logic fast_req;

   assign fast_req = (irq_level > irq_thr) || (risc_en && risc_busy);

   always_comb begin
      if (!src_sel) begin
         want_code = '0;
         want_rate = RATE_NORM;
      end else if (fast_req) begin
         want_code = high_code;
         want_rate = RATE_HIGH;
      end else begin
         want_code = low_code;
         want_rate = RATE_LOW;
      end
   end

endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
   import sysclk_pkg::*;
#(
   parameter int unsigned DIV_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  want_code,
   input  rate_e             want_rate,
   output logic              sys_ce,
   output logic              sys2x_ce,
   output rate_e             rate_q
);
   localparam int unsigned MAX_CODE = (1 << DIV_W) - 1;
   localparam int unsigned CNT_W    = 2 * MAX_CODE + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;
   logic [CNT_W:0]   span;
   logic [DIV_W-1:0] act_code;

   assign span = (CNT_W + 1)'(2) << (2 * act_code);
   assign last = CNT_W'(span - 1'b1);

   assign sys_ce   = (cnt_q == last);
   assign sys2x_ce = sys_ce || (cnt_q == (last >> 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         act_code <= '0;
         rate_q   <= RATE_NORM;
      end else if (sys_ce) begin
         cnt_q    <= '0;
         act_code <= want_code;
         rate_q   <= want_rate;
      end else begin
         cnt_q    <= cnt_q + 1'b1;
      end
   end

   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_ce |=> $stable(act_code)); // R8
   AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_ce |=> $stable(rate_q)); // R11

endmodule

// File: rtl/sysclk_tmr_prescaler.sv
module sysclk_tmr_prescaler #(
   parameter int unsigned PRE_LOG2 = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_pins,
   output logic       tmr_ce
);
   logic pass;

   assign pass = (mode_pins == 2'b11);

   generate
      if (PRE_LOG2 == 0) begin : g_direct
         assign tmr_ce = 1'b1;
      end else begin : g_count
         logic [PRE_LOG2-1:0] pcnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pcnt_q <= '0;
            else
               pcnt_q <= pcnt_q + 1'b1;
         end

         assign tmr_ce = pass | (&pcnt_q);

         AST_TMR_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_ce && !pass) |=> (!tmr_ce || pass)); // R10
      end
   endgenerate

endmodule

// File: rtl/sysclk_rate_ctrl.sv
module sysclk_rate_ctrl
   import sysclk_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned DIV_W     = 3,
   parameter int unsigned CTRL_ADDR = 0,
   parameter int unsigned PRE_LOG2  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_wr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic [2:0]        irq_level,
   input  logic              risc_busy,
   input  logic [1:0]        mode_pins,
   output logic              sys_ce,
   output logic              sys2x_ce,
   output logic              tmr_ce,
   output logic [1:0]        rate_o
);
   generate
      if (DATA_W < cfg_bits(DIV_W)) begin : g_bad_width
         $error("DATA_W too small for the control fields");
      end
      if (DIV_W < 1 || DIV_W > 3) begin : g_bad_div
         $error("DIV_W must be 1 to 3");
      end
      if (CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("CTRL_ADDR does not fit ADDR_W");
      end
   endgenerate

   logic              src_sel, risc_en;
   logic [DIV_W-1:0]  low_code, high_code, want_code;
   logic [THR_W-1:0]  irq_thr;
   rate_e             want_rate, rate_q;

   sysclk_cfg_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .CTRL_ADDR(CTRL_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(cfg_addr), .wr_en(cfg_wr),
      .wr_data(cfg_wdata), .rd_data(cfg_rdata), .src_sel(src_sel),
      .low_code(low_code), .high_code(high_code), .irq_thr(irq_thr),
      .risc_en(risc_en)
   );

   sysclk_rate_policy #(.DIV_W(DIV_W)) u_policy (
      .src_sel(src_sel), .low_code(low_code), .high_code(high_code),
      .irq_thr(irq_thr), .risc_en(risc_en), .irq_level(irq_level),
      .risc_busy(risc_busy), .want_code(want_code), .want_rate(want_rate)
   );

   sysclk_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .want_code(want_code), .want_rate(want_rate),
      .sys_ce(sys_ce), .sys2x_ce(sys2x_ce), .rate_q(rate_q)
   );

   sysclk_tmr_prescaler #(.PRE_LOG2(PRE_LOG2)) u_tmr (
      .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .tmr_ce(tmr_ce)
   );

   assign rate_o = rate_q;

   AST_SRC_OFF_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_ce && !src_sel) |=> rate_o == RATE_NORM); // R3
   AST_IRQ_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_ce && src_sel && (irq_level > irq_thr)) |=> rate_o == RATE_HIGH); // R5
   AST_RISC_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_ce && src_sel && risc_en && risc_busy) |=> rate_o == RATE_HIGH); // R6

endmodule

// File: tb/sysclk_rate_ctrl_test.sv
module sysclk_rate_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic        cfg_wr = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic [2:0]  irq_level = '0;
   logic        risc_busy = 1'b0;
   logic [1:0]  mode_pins = 2'b11;
   logic        sys_ce, sys2x_ce, tmr_ce;
   logic [1:0]  rate_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sysclk_rate_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_level(irq_level),
      .risc_busy(risc_busy), .mode_pins(mode_pins), .sys_ce(sys_ce),
      .sys2x_ce(sys2x_ce), .tmr_ce(tmr_ce), .rate_o(rate_o)
   );

   // entry: ctrl[29:14] irq[13:11] busy[10] period[9:2] rate[1:0]
   localparam int NV = 10;
   localparam logic [29:0] VEC [NV] = '{
      {16'h0000, 3'd7, 1'b1, 8'd2,   2'd0},  // R3 source off
      {16'h0003, 3'd0, 1'b0, 8'd8,   2'd1},  // R4 low code 1
      {16'h0195, 3'd3, 1'b0, 8'd32,  2'd1},  // R5 level equal to threshold
      {16'h0195, 3'd4, 1'b0, 8'd8,   2'd2},  // R5 R7 level above threshold
      {16'h0185, 3'd4, 1'b0, 8'd2,   2'd2},  // R7 high code 0
      {16'h0423, 3'd0, 1'b1, 8'd32,  2'd2},  // R6 busy with enable
      {16'h0423, 3'd0, 1'b0, 8'd8,   2'd1},  // R6 idle
      {16'h0023, 3'd0, 1'b1, 8'd8,   2'd1},  // R6 busy without enable
      {16'h0422, 3'd7, 1'b1, 8'd2,   2'd0},  // R3 fields set, source off
      {16'h0007, 3'd0, 1'b0, 8'd128, 2'd1}   // R4 low code 3
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic wait_sys();
      do @(negedge clk); while (!sys_ce);
   endtask

   task automatic measure(output int per, output int n2x);
      per = 0; n2x = 0;
      do begin
         @(negedge clk);
         per++;
         if (sys2x_ce) n2x++;
      end while (!sys_ce);
   endtask

   task automatic tmr_gap(output int gap);
      gap = 0;
      do @(negedge clk); while (!tmr_ce);
      do begin @(negedge clk); gap++; end while (!tmr_ce);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      int per, n2x, gap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk(cfg_rdata == 16'h0, "R1 reg", cfg_rdata, 0);
      chk(rate_o == 2'd0, "R1 rate", rate_o, 0);
      wait_sys();
      measure(per, n2x);
      chk(per == 2, "R1 period", per, 2);

      // table of configurations
      for (int i = 0; i < NV; i++) begin
         cfg_write(4'd0, VEC[i][29:14]);
         irq_level = VEC[i][13:11];
         risc_busy = VEC[i][10];
         wait_sys();
         measure(per, n2x);
         chk(per == int'(VEC[i][9:2]), $sformatf("R4/R7 vec%0d period", i), per, int'(VEC[i][9:2]));
         chk(n2x == 2, $sformatf("R9 vec%0d 2x count", i), n2x, 2);
         chk(rate_o == VEC[i][1:0], $sformatf("R11 vec%0d rate", i), rate_o, int'(VEC[i][1:0]));
      end
      irq_level = 3'd0; risc_busy = 1'b0;

      // R2 readback and address decoding
      cfg_write(4'd0, 16'hFFFF);
      chk(cfg_rdata == 16'h07FF, "R2 readback mask", cfg_rdata, 16'h07FF);
      cfg_write(4'd5, 16'h0001);
      chk(cfg_rdata == 16'h0, "R2 other addr reads 0", cfg_rdata, 0);
      cfg_addr = 4'd0;
      @(negedge clk);
      chk(cfg_rdata == 16'h07FF, "R2 other addr write ignored", cfg_rdata, 16'h07FF);

      // R8 change waits for the period boundary
      cfg_write(4'd0, 16'h0007);
      wait_sys();
      measure(per, n2x);
      chk(per == 128, "R8 setup period", per, 128);
      repeat (10) @(negedge clk);
      cfg_write(4'd0, 16'h0000);
      chk(rate_o == 2'd1, "R8 rate held mid period", rate_o, 1);
      measure(per, n2x);
      chk(per == 116, "R8 old period completes", per, 116);
      measure(per, n2x);
      chk(per == 2, "R8 new period after boundary", per, 2);
      chk(rate_o == 2'd0, "R8 R11 rate after boundary", rate_o, 0);

      // R10 timer enable
      mode_pins = 2'b11;
      n2x = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (tmr_ce) n2x++;
      end
      chk(n2x == 20, "R10 mode 11 every cycle", n2x, 20);
      mode_pins = 2'b01;
      tmr_gap(gap);
      chk(gap == 128, "R10 mode 01 divide", gap, 128);
      mode_pins = 2'b00;
      tmr_gap(gap);
      chk(gap == 128, "R10 mode 00 divide", gap, 128);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule